// File: doc/BRIEF.md
# Integer ALU with Flag Register

A 16-bit arithmetic and logic unit with a byte/word width select. It is coupled to a 16-bit flag register. An operation is presented with `valid_i`. Add, subtract, AND, OR and XOR produce a registered result and update six status flags one cycle later: carry, parity, auxiliary carry, zero, sign and overflow.

The same operation code also carries flag commands. These set or clear the carry flag and three control flags: trap, interrupt enable and direction. The control flags change only through these commands. The unit computes no other effect of them.

In byte mode only the low byte is computed. The high byte of the result keeps the destination operand `a_i[15:8]`, so the result can be written straight back to the destination register.

Top module: `alu_flags`

## Requirements
- R1: Operation code 0 (add) gives a result of a+b and sets carry (flag bit 0) to the carry out of bit 7 in byte mode or bit 15 in word mode.
- R2: Operation code 1 (subtract) gives a result of a-b and sets carry to the borrow out of the top bit of the selected width.
- R3: Operation codes 2, 3 and 4 give a AND b, a OR b and a XOR b, and clear carry (bit 0), auxiliary carry (bit 2) and overflow (bit 5).
- R4: Zero (bit 3) is set when the result is all zero within the selected width. Sign (bit 4) copies result bit 7 in byte mode and bit 15 in word mode.
- R5: Parity (bit 1) is set when result bits 7:0 hold an even number of ones, in both widths.
- R6: For add and subtract, auxiliary carry (bit 2) is the carry or borrow out of bit 3.
- R7: For add and subtract, overflow (bit 5) is set on two's-complement overflow of the selected width.
- R8: In byte mode (`word_i`=0), result bits 15:8 equal `a_i[15:8]`.
- R9: Codes 8 to 15 clear or set one flag. Bit 0 of the code is the new value. Codes 8/9 act on carry (bit 0), 10/11 on direction (bit 10), 12/13 on interrupt enable (bit 9) and 14/15 on trap (bit 8). No other flag changes, and `res_valid_o` stays low.
- R10: Add, subtract and logic operations leave bits 8, 9 and 10 unchanged.
- R11: Codes 5, 6 and 7 are no-ops. Flags stay unchanged and `res_valid_o` stays low.
- R12: After reset, the flags, the result and `res_valid_o` are zero. Flag bits 6, 7 and 11 to 15 always read zero.
- R13: For a valid add, subtract or logic operation, the result, `res_valid_o` and the status flags appear on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation or flag command code |
| word_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| a_i | input | 16 | Destination / first operand |
| b_i | input | 16 | Second operand |
| result_o | output | 16 | Registered result |
| res_valid_o | output | 1 | Result valid, one cycle after an ALU operation |
| flags_o | output | 16 | Flag register |

## Verification
The assertions assume that `op_i` and `word_i` are meaningful only when `valid_i` is high. They also assume that one sampled operation maps to one flag update at the next edge, so the properties relate each flag change to the code seen one cycle earlier. The bench drives every operation for exactly one cycle at the falling edge and returns `valid_i` to low between operations. It includes the reserved codes, so each `$past` reference lines up with a single sampled operation.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3, OP_XOR = 4'd4,
    OP_CLR_C = 4'd8, OP_SET_C = 4'd9, OP_CLR_D = 4'd10, OP_SET_D = 4'd11,
    OP_CLR_I = 4'd12, OP_SET_I = 4'd13, OP_CLR_T = 4'd14, OP_SET_T = 4'd15
  } alu_op_e;

  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;
  localparam int F_TF = 8;
  localparam int F_IF = 9;
  localparam int F_DF = 10;
  localparam int FLAG_W = 16;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } status_t;
endpackage

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output status_t           st_o,
  output logic              is_alu_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0]   ext_a, ext_b, full;
  logic [DATA_W-1:0] raw;
  logic              msb_a, msb_b, msb_r, is_arith;

  always_comb begin
    ext_a = word_i ? {1'b0, a_i} : {{(HALF_W+1){1'b0}}, a_i[HALF_W-1:0]};
    ext_b = word_i ? {1'b0, b_i} : {{(HALF_W+1){1'b0}}, b_i[HALF_W-1:0]};
    is_arith = 1'b0;
    is_alu_o = 1'b1;
    full = '0;
    unique case (op_i)
      OP_ADD: begin full = ext_a + ext_b; is_arith = 1'b1; end
      OP_SUB: begin full = ext_a - ext_b; is_arith = 1'b1; end
      OP_AND: full = ext_a & ext_b;
      OP_OR:  full = ext_a | ext_b;
      OP_XOR: full = ext_a ^ ext_b;
      default: is_alu_o = 1'b0;
    endcase
    raw = full[DATA_W-1:0];
    res_o = word_i ? raw : {a_i[DATA_W-1:HALF_W], raw[HALF_W-1:0]};
    msb_a = word_i ? a_i[DATA_W-1] : a_i[HALF_W-1];
    msb_b = word_i ? b_i[DATA_W-1] : b_i[HALF_W-1];
    msb_r = word_i ? raw[DATA_W-1] : raw[HALF_W-1];

    st_o.cf = is_arith & (word_i ? full[DATA_W] : full[HALF_W]);
    st_o.af = is_arith & (a_i[4] ^ b_i[4] ^ raw[4]);
    // add: like signs give unlike result; sub: unlike signs, result leaves a's sign
    st_o.of = is_arith & (msb_r != msb_a) &
              ((op_i == OP_ADD) ? (msb_a == msb_b) : (msb_a != msb_b));
    st_o.pf = ~^raw[7:0];
    st_o.zf = word_i ? (raw == '0) : (raw[HALF_W-1:0] == '0);
    st_o.sf = msb_r;
  end
endmodule

// File: rtl/alu_flags_reg.sv
module alu_flags_reg
  import alu_flags_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alu_we_i,
  input  logic              cmd_we_i,
  input  logic [3:0]        op_i,
  input  status_t           st_i,
  output logic [FLAG_W-1:0] flags_o
);
  status_t st_q;
  logic    tf_q, if_q, df_q;
  logic    set_v;

  assign set_v = op_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      tf_q <= 1'b0;
      if_q <= 1'b0;
      df_q <= 1'b0;
    end else if (alu_we_i) begin
      st_q <= st_i;
    end else if (cmd_we_i) begin
      unique case (op_i[2:1])
        2'd0: st_q.cf <= set_v;
        2'd1: df_q    <= set_v;
        2'd2: if_q    <= set_v;
        default: tf_q <= set_v;
      endcase
    end
  end

  always_comb begin
    flags_o       = '0;
    flags_o[F_CF] = st_q.cf;
    flags_o[F_PF] = st_q.pf;
    flags_o[F_AF] = st_q.af;
    flags_o[F_ZF] = st_q.zf;
    flags_o[F_SF] = st_q.sf;
    flags_o[F_OF] = st_q.of;
    flags_o[F_TF] = tf_q;
    flags_o[F_IF] = if_q;
    flags_o[F_DF] = df_q;
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              res_valid_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DATA_W-1:0] res_d;
  status_t           st_d;
  logic              is_alu;

  alu_flags_core #(.DATA_W(DATA_W)) u_core (
    .op_i    (op_i),
    .word_i  (word_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_o   (res_d),
    .st_o    (st_d),
    .is_alu_o(is_alu)
  );

  alu_flags_reg u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alu_we_i(valid_i & is_alu),
    .cmd_we_i(valid_i & op_i[3]),
    .op_i    (op_i),
    .st_i    (st_d),
    .flags_o (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= valid_i & is_alu;
      if (valid_i && is_alu) result_o <= res_d;
    end
  end
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [3:0]  op_i,
  input logic        word_i,
  input logic [15:0] result_o,
  input logic        res_valid_o,
  input logic [15:0] flags_o
);
  p_unused_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & 16'hF8C0) == 16'h0);

  p_logic_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i inside {4'd2, 4'd3, 4'd4}) |=>
      (!flags_o[0] && !flags_o[2] && !flags_o[5]));

  p_ctrl_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 4'd4) |=> $stable(flags_o[10:8]));

  p_set_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd9) |=> (flags_o[0] && !res_valid_o));

  p_noop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i inside {4'd5, 4'd6, 4'd7}) |=> ($stable(flags_o) && !res_valid_o));

  p_parity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (flags_o[1] == ~^result_o[7:0]));

  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (flags_o[3] == ($past(word_i) ? (result_o == 16'h0)
                                                   : (result_o[7:0] == 8'h0))));

  p_latency_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(valid_i));
endmodule

bind alu_flags alu_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .word_i     (word_i),
  .result_o   (result_o),
  .res_valid_o(res_valid_o),
  .flags_o    (flags_o)
);

// File: tb/alu_flags_tb_top.sv
module alu_flags_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        word_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [15:0] result_o, flags_o;
  logic        res_valid_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] flag_m = '0;

  typedef struct {
    logic [15:0] res;
    logic [15:0] flg;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alu_flags dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .word_i(word_i), .a_i(a_i), .b_i(b_i), .result_o(result_o),
    .res_valid_o(res_valid_o), .flags_o(flags_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference from the requirement text, bit layout of R1..R9
  function automatic item_t model(logic [3:0] op, logic w, logic [15:0] a, logic [15:0] b,
                                  string tag);
    item_t it;
    logic [16:0] ea, eb, f;
    logic [15:0] r;
    logic sa, sb, sr, arith;
    ea = w ? {1'b0, a} : {9'b0, a[7:0]};
    eb = w ? {1'b0, b} : {9'b0, b[7:0]};
    arith = (op <= 4'd1);
    case (op)
      4'd0: f = ea + eb;
      4'd1: f = ea - eb;
      4'd2: f = ea & eb;
      4'd3: f = ea | eb;
      default: f = ea ^ eb;
    endcase
    r = w ? f[15:0] : {a[15:8], f[7:0]};
    sa = w ? a[15] : a[7];
    sb = w ? b[15] : b[7];
    sr = w ? f[15] : f[7];
    it.res = r;
    it.flg = flag_m & 16'h0700;
    it.flg[0] = arith & (w ? f[16] : f[8]);
    it.flg[1] = ~^f[7:0];
    it.flg[2] = arith & ((a[3:0] + (op == 4'd0 ? b[3:0] : -b[3:0])) > 5'd15 ||
                         (op == 4'd1 && b[3:0] > a[3:0]));
    if (op == 4'd0) it.flg[2] = arith & (({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15);
    if (op == 4'd1) it.flg[2] = b[3:0] > a[3:0];
    it.flg[3] = w ? (f[15:0] == 0) : (f[7:0] == 0);
    it.flg[4] = sr;
    it.flg[5] = arith & (op == 4'd0 ? (sa == sb && sr != sa) : (sa != sb && sr != sa));
    it.tag = tag;
    return it;
  endfunction

  task automatic do_op(logic [3:0] op, logic w, logic [15:0] a, logic [15:0] b, string tag);
    item_t it;
    @(negedge clk_i);
    op_i = op; word_i = w; a_i = a; b_i = b; valid_i = 1'b1;
    if (op <= 4'd4) begin
      it = model(op, w, a, b, tag);
      flag_m = it.flg;
      sb_q.push_back(it);
    end else if (op[3]) begin
      case (op[2:1])
        2'd0: flag_m[0]  = op[0];
        2'd1: flag_m[10] = op[0];
        2'd2: flag_m[9]  = op[0];
        default: flag_m[8] = op[0];
      endcase
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    if (op > 4'd4) begin
      check({tag, " flags"}, {16'h0, flags_o}, {16'h0, flag_m});
      check({tag, " no result"}, {31'h0, res_valid_o}, 32'h0);
    end
  endtask

  // monitor: compare each produced result with the queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (sb_q.size() == 0) begin
        check("R13 unexpected result", 32'h1, 32'h0);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        check({e.tag, " result"}, {16'h0, result_o}, {16'h0, e.res});
        check({e.tag, " flags"}, {16'h0, flags_o}, {16'h0, e.flg});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R12 reset flags", {16'h0, flags_o}, 32'h0);
    check("R12 reset result", {15'h0, res_valid_o, result_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    do_op(4'd0, 1'b1, 16'h4321, 16'h1000, "R1 add word");
    do_op(4'd0, 1'b1, 16'hFFFF, 16'h0001, "R1 R4 add word carry zero");
    do_op(4'd0, 1'b0, 16'hAB80, 16'h1280, "R1 R8 R7 add byte carry overflow");
    do_op(4'd0, 1'b0, 16'h120F, 16'h0001, "R6 add byte aux carry");
    do_op(4'd0, 1'b1, 16'h7FFF, 16'h0001, "R7 R4 add word overflow sign");
    do_op(4'd1, 1'b1, 16'h0000, 16'h0001, "R2 sub word borrow");
    do_op(4'd1, 1'b0, 16'h5510, 16'h0001, "R2 R6 R8 sub byte aux borrow");
    do_op(4'd1, 1'b0, 16'h0080, 16'h0001, "R7 sub byte overflow");
    do_op(4'd1, 1'b1, 16'h8000, 16'h0001, "R7 sub word overflow");
    do_op(4'd1, 1'b0, 16'hFF42, 16'hAA42, "R4 sub byte zero");
    do_op(4'd9, 1'b0, 16'h0, 16'h0, "R9 set carry");
    do_op(4'd11, 1'b0, 16'h0, 16'h0, "R9 set direction");
    do_op(4'd13, 1'b0, 16'h0, 16'h0, "R9 set interrupt");
    do_op(4'd15, 1'b0, 16'h0, 16'h0, "R9 set trap");
    do_op(4'd2, 1'b1, 16'hF0F0, 16'h3C3C, "R3 R10 and word");
    do_op(4'd3, 1'b0, 16'h7781, 16'h0002, "R3 R5 R8 or byte");
    do_op(4'd4, 1'b1, 16'h1234, 16'h1234, "R3 R4 xor word zero");
    do_op(4'd0, 1'b1, 16'h0103, 16'h0000, "R5 parity odd");
    do_op(4'd5, 1'b1, 16'h1111, 16'h2222, "R11 reserved 5");
    do_op(4'd7, 1'b0, 16'hFFFF, 16'hFFFF, "R11 reserved 7");
    do_op(4'd8, 1'b0, 16'h0, 16'h0, "R9 clear carry");
    do_op(4'd10, 1'b0, 16'h0, 16'h0, "R9 clear direction");
    do_op(4'd12, 1'b0, 16'h0, 16'h0, "R9 clear interrupt");
    do_op(4'd14, 1'b0, 16'h0, 16'h0, "R9 clear trap");
    do_op(4'd1, 1'b1, 16'h1234, 16'h0235, "R2 R6 R13 sub word");
    repeat (2) @(negedge clk_i);
    check("R13 queue drained", sb_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule